// File: doc/BRIEF.md
# Register Sidecar Permission Checker

This block checks the access rights of loads, stores and instruction fetches that form their address as a base register plus an immediate. Each of the eight address registers carries a small side cache, called a sidecar here. The sidecar remembers the lower limit, the upper limit and the access right of the region that the register last reached. When the effective address falls inside that remembered region, the right is judged at once and the protection lookaside buffer is left alone.

On a sidecar miss, the block raises a lookup request toward the lookaside buffer and holds it. It waits for the response handshake, loads the returned region into the sidecar of that register, and then reports the outcome. The check only has to finish before the instruction retires, so a miss may take several cycles. When the register file writes a new value into a register, the sidecar of that register is dropped.

Two free-running counters report how many checks took the sidecar path and how many took the lookup path.

Top module: `sidecar_perm_checker`

## Requirements
- R1: The effective address is `base_val + offset`, modulo 2^32. On a miss, `lkp_addr` carries that address.
- R2: A check hits when the sidecar of the addressed register is valid and `lo <= addr < hi`, both compares unsigned. On a hit, `chk_done` pulses one cycle after acceptance and `lkp_valid` stays low.
- R3: Access kinds are encoded READ=0, WRITE=1, FETCH=2 and reserved=3. Rights are encoded NONE=0, RO=1, RW=2, XR=3. A READ is allowed with RO, RW or XR. A READ with NONE faults.
- R4: A WRITE is allowed only with RW. Any other right makes a WRITE fault.
- R5: A FETCH is allowed only with XR. The reserved kind 3 always faults.
- R6: After a miss is accepted, `lkp_valid` and `busy` are high from the next cycle until the response cycle. During that time `lkp_addr` is stable and new requests are ignored: they change neither counter.
- R7: In the cycle after `rsp_valid` is seen during a lookup, `chk_done` pulses, with `chk_fault` judged from `rsp_perm`. The region is loaded into the sidecar, so a later access inside it hits.
- R8: Setting `wr_en` with `wr_idx` drops the sidecar of that register, so the next access through it misses. The sidecars of other registers are unaffected.
- R9: `hits` increments by one for each hit and `misses` by one for each accepted miss. Both wrap.
- R10: After reset, `chk_done`, `chk_fault`, `busy` and `lkp_valid` are low, both counters are zero, and every sidecar is empty.
- R11: When a register write and a refill target the same sidecar in the same cycle, the sidecar ends up empty.
- R12: The upper limit is exclusive and the lower limit is inclusive. An address equal to `hi` misses; an address equal to `lo` hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Check request, taken when `busy` is low |
| req_idx | input | 3 | Base register number |
| req_base | input | 32 | Base register value |
| req_offset | input | 32 | Immediate offset |
| req_kind | input | 2 | Access kind (R3) |
| wr_en | input | 1 | Register file write strobe |
| wr_idx | input | 3 | Register being written |
| lkp_valid | output | 1 | Lookup request, held until the response |
| lkp_addr | output | 32 | Address to look up |
| rsp_valid | input | 1 | Lookup response strobe |
| rsp_lo | input | 32 | Region lower limit, inclusive |
| rsp_hi | input | 32 | Region upper limit, exclusive |
| rsp_perm | input | 2 | Region access right |
| busy | output | 1 | Lookup in progress |
| chk_done | output | 1 | Check complete, one-cycle pulse |
| chk_fault | output | 1 | Protection fault, valid with `chk_done` |
| hits | output | 16 | Sidecar hit count |
| misses | output | 16 | Sidecar miss count |

## Verification
The assertions assume a few things about the lookaside buffer. It raises `rsp_valid` only while `lkp_valid` is high. It returns a region that contains the requested address. It sends no response outside a lookup. The stimulus keeps to this: every response is driven only after the bench sees `lkp_valid`, and each returned region encloses the address the bench computed. Extra requests are issued during a stretched lookup so that the ignore rule is exercised while the response is still being withheld.

// File: rtl/sidecar_pkg.sv
package sidecar_pkg;

  typedef enum logic [1:0] {
    PERM_NONE = 2'd0,
    PERM_RO   = 2'd1,
    PERM_RW   = 2'd2,
    PERM_XR   = 2'd3
  } perm_e;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } chk_state_e;

endpackage

// File: rtl/sc_access_rule.sv
module sc_access_rule
  import sidecar_pkg::*;
(
  input  perm_e perm,
  input  acc_e  kind,
  output logic  allow
);

  // R3 R4 R5: rights table per access kind
  always_comb begin
    unique case (kind)
      ACC_READ:  allow = (perm != PERM_NONE);
      ACC_WRITE: allow = (perm == PERM_RW);
      ACC_FETCH: allow = (perm == PERM_XR);
      default:   allow = 1'b0;
    endcase
  end

endmodule

// File: rtl/sc_entry_bank.sv
module sc_entry_bank
  import sidecar_pkg::*;
#(
  parameter int NREG = 8,
  parameter int AW   = 32,
  localparam int IW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inv_en,
  input  logic [IW-1:0] inv_idx,
  input  logic          fill_en,
  input  logic [IW-1:0] fill_idx,
  input  logic [AW-1:0] fill_lo,
  input  logic [AW-1:0] fill_hi,
  input  perm_e         fill_perm,
  input  logic [IW-1:0] rd_idx,
  input  logic [AW-1:0] rd_addr,
  output logic          rd_hit,
  output perm_e         rd_perm
);

  logic [NREG-1:0] vld_q, vld_d;
  logic [AW-1:0]   lo_q [NREG];
  logic [AW-1:0]   hi_q [NREG];
  perm_e           pm_q [NREG];

  // R8 R11: invalidate takes priority over refill
  always_comb begin
    for (int i = 0; i < NREG; i++) begin
      vld_d[i] = vld_q[i];
      if (fill_en && fill_idx == IW'(i)) vld_d[i] = 1'b1;
      if (inv_en && inv_idx == IW'(i))   vld_d[i] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  for (genvar g = 0; g < NREG; g++) begin : g_entry
    logic load_g;
    assign load_g = fill_en && (fill_idx == IW'(g));
    always_ff @(posedge clk) begin
      if (load_g) begin
        lo_q[g] <= fill_lo;
        hi_q[g] <= fill_hi;
        pm_q[g] <= fill_perm;
      end
    end
  end

  logic [AW-1:0] sel_lo, sel_hi;
  assign sel_lo  = lo_q[rd_idx];
  assign sel_hi  = hi_q[rd_idx];
  assign rd_perm = pm_q[rd_idx];
  // R2 R12: inclusive lower, exclusive upper, unsigned
  assign rd_hit  = vld_q[rd_idx] && (rd_addr >= sel_lo) && (rd_addr < sel_hi);

  a_r8_invalidate_wins: assert property (@(posedge clk) disable iff (!rst_n)
    inv_en |=> !vld_q[$past(inv_idx)]);

  a_r7_fill_sets_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && !(inv_en && inv_idx == fill_idx)) |=> vld_q[$past(fill_idx)]);

endmodule

// File: rtl/sc_miss_ctrl.sv
module sc_miss_ctrl
  import sidecar_pkg::*;
#(
  parameter int NREG = 8,
  parameter int AW   = 32,
  parameter int CW   = 16,
  localparam int IW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [IW-1:0] req_idx,
  input  logic [AW-1:0] req_addr,
  input  acc_e          req_kind,
  input  logic          sc_hit,
  input  logic          sc_allow,
  input  logic          rsp_valid,
  input  logic          rsp_allow,
  output acc_e          pend_kind,
  output logic          fill_en,
  output logic [IW-1:0] fill_idx,
  output logic          lkp_valid,
  output logic [AW-1:0] lkp_addr,
  output logic          busy,
  output logic          done,
  output logic          fault,
  output logic [CW-1:0] hit_cnt,
  output logic [CW-1:0] miss_cnt
);

  chk_state_e    st_q, st_d;
  logic [AW-1:0] addr_q;
  logic [IW-1:0] idx_q;
  acc_e          kind_q;
  logic          done_q, done_d, fault_q, fault_d;
  logic [CW-1:0] hit_q, miss_q;
  logic          accept, take_hit, take_miss, rsp_take;

  assign accept    = req_valid && (st_q == ST_IDLE);
  assign take_hit  = accept && sc_hit;
  assign take_miss = accept && !sc_hit;
  assign rsp_take  = (st_q == ST_WAIT) && rsp_valid;

  always_comb begin
    st_d    = st_q;
    done_d  = 1'b0;
    fault_d = 1'b0;
    if (take_hit) begin
      done_d  = 1'b1;
      fault_d = !sc_allow;
    end else if (take_miss) begin
      st_d = ST_WAIT;
    end else if (rsp_take) begin
      st_d    = ST_IDLE;
      done_d  = 1'b1;
      fault_d = !rsp_allow;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      hit_q   <= '0;
      miss_q  <= '0;
    end else begin
      st_q    <= st_d;
      done_q  <= done_d;
      fault_q <= fault_d;
      if (take_hit)  hit_q  <= hit_q + {{(CW-1){1'b0}}, 1'b1};
      if (take_miss) miss_q <= miss_q + {{(CW-1){1'b0}}, 1'b1};
    end
  end

  always_ff @(posedge clk) begin
    if (take_miss) begin
      addr_q <= req_addr;
      idx_q  <= req_idx;
      kind_q <= req_kind;
    end
  end

  assign pend_kind = kind_q;
  assign fill_en   = rsp_take;
  assign fill_idx  = idx_q;
  assign lkp_valid = (st_q == ST_WAIT);
  assign busy      = (st_q == ST_WAIT);
  assign lkp_addr  = addr_q;
  assign done      = done_q;
  assign fault     = fault_q;
  assign hit_cnt   = hit_q;
  assign miss_cnt  = miss_q;

  a_r2_hit_no_lookup: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && sc_hit) |=> (done && !lkp_valid));

  a_r6_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    (lkp_valid && !rsp_valid) |=> (lkp_valid && $stable(lkp_addr) && $stable(miss_cnt) && $stable(hit_cnt)));

  a_r7_done_after_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    (lkp_valid && rsp_valid) |=> (done && !busy));

  a_r7_done_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r9_hit_step: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(hit_cnt) |-> (hit_cnt == $past(hit_cnt) + 1'b1) && $stable(miss_cnt));

  a_r9_miss_step: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(miss_cnt) |-> (miss_cnt == $past(miss_cnt) + 1'b1) && lkp_valid);

endmodule

// File: rtl/sidecar_perm_checker.sv
module sidecar_perm_checker
  import sidecar_pkg::*;
#(
  parameter int NREG = 8,
  parameter int AW   = 32,
  parameter int CW   = 16,
  localparam int IW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [IW-1:0] req_idx,
  input  logic [AW-1:0] req_base,
  input  logic [AW-1:0] req_offset,
  input  logic [1:0]    req_kind,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  output logic          lkp_valid,
  output logic [AW-1:0] lkp_addr,
  input  logic          rsp_valid,
  input  logic [AW-1:0] rsp_lo,
  input  logic [AW-1:0] rsp_hi,
  input  logic [1:0]    rsp_perm,
  output logic          busy,
  output logic          chk_done,
  output logic          chk_fault,
  output logic [CW-1:0] hits,
  output logic [CW-1:0] misses
);

  logic [AW-1:0] eff_addr;
  logic          sc_hit, sc_allow, rsp_allow, fill_en;
  logic [IW-1:0] fill_idx;
  perm_e         sc_perm;
  acc_e          pend_kind;

  // R1: effective address wraps modulo 2^AW
  assign eff_addr = req_base + req_offset;

  sc_entry_bank #(.NREG(NREG), .AW(AW)) bank_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .inv_en    (wr_en),
    .inv_idx   (wr_idx),
    .fill_en   (fill_en),
    .fill_idx  (fill_idx),
    .fill_lo   (rsp_lo),
    .fill_hi   (rsp_hi),
    .fill_perm (perm_e'(rsp_perm)),
    .rd_idx    (req_idx),
    .rd_addr   (eff_addr),
    .rd_hit    (sc_hit),
    .rd_perm   (sc_perm)
  );

  sc_access_rule hit_rule_i (
    .perm  (sc_perm),
    .kind  (acc_e'(req_kind)),
    .allow (sc_allow)
  );

  sc_access_rule rsp_rule_i (
    .perm  (perm_e'(rsp_perm)),
    .kind  (pend_kind),
    .allow (rsp_allow)
  );

  sc_miss_ctrl #(.NREG(NREG), .AW(AW), .CW(CW)) ctrl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_idx   (req_idx),
    .req_addr  (eff_addr),
    .req_kind  (acc_e'(req_kind)),
    .sc_hit    (sc_hit),
    .sc_allow  (sc_allow),
    .rsp_valid (rsp_valid),
    .rsp_allow (rsp_allow),
    .pend_kind (pend_kind),
    .fill_en   (fill_en),
    .fill_idx  (fill_idx),
    .lkp_valid (lkp_valid),
    .lkp_addr  (lkp_addr),
    .busy      (busy),
    .done      (chk_done),
    .fault     (chk_fault),
    .hit_cnt   (hits),
    .miss_cnt  (misses)
  );

  a_r1_lookup_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && !sc_hit) |=> (lkp_addr == $past(req_base) + $past(req_offset)));

endmodule

// File: tb/sidecar_perm_checker_tb_top.sv
module sidecar_perm_checker_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, wr_en, rsp_valid;
  logic [2:0]  req_idx, wr_idx;
  logic [31:0] req_base, req_offset, rsp_lo, rsp_hi;
  logic [1:0]  req_kind, rsp_perm;
  logic        lkp_valid, busy, chk_done, chk_fault;
  logic [31:0] lkp_addr;
  logic [15:0] hits, misses;

  int n_checks = 0;
  int n_fail   = 0;
  int exp_hits = 0;
  int exp_miss = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  sidecar_perm_checker dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_idx(req_idx),
    .req_base(req_base), .req_offset(req_offset), .req_kind(req_kind),
    .wr_en(wr_en), .wr_idx(wr_idx), .lkp_valid(lkp_valid), .lkp_addr(lkp_addr),
    .rsp_valid(rsp_valid), .rsp_lo(rsp_lo), .rsp_hi(rsp_hi), .rsp_perm(rsp_perm),
    .busy(busy), .chk_done(chk_done), .chk_fault(chk_fault),
    .hits(hits), .misses(misses)
  );

  typedef struct packed {
    logic [2:0]  rg;
    logic [31:0] val;
    logic [31:0] imm;
    logic [1:0]  kind;
    logic [31:0] lo;
    logic [31:0] hi;
    logic [1:0]  pm;
    logic        hit;
    logic        flt;
  } vec_t;

  localparam int NV = 14;
  // kind: 0 READ 1 WRITE 2 FETCH 3 reserved; perm: 0 NONE 1 RO 2 RW 3 XR
  localparam vec_t TBL [NV] = '{
    '{3'd1, 32'h0000_1000, 32'h0000_0010, 2'd0, 32'h0000_1000, 32'h0000_1100, 2'd1, 1'b0, 1'b0}, // R1 R3 miss
    '{3'd1, 32'h0000_1000, 32'h0000_0020, 2'd1, 32'h0,         32'h0,         2'd0, 1'b1, 1'b1}, // R4 write RO
    '{3'd1, 32'h0000_10F0, 32'h0000_000C, 2'd0, 32'h0,         32'h0,         2'd0, 1'b1, 1'b0}, // R2 top word
    '{3'd1, 32'h0000_10F0, 32'h0000_0010, 2'd0, 32'h0000_1100, 32'h0000_1180, 2'd2, 1'b0, 1'b0}, // R12 at hi
    '{3'd1, 32'h0000_1100, 32'h0000_0000, 2'd1, 32'h0,         32'h0,         2'd0, 1'b1, 1'b0}, // R12 at lo, R4
    '{3'd1, 32'h0000_1100, 32'h0000_0000, 2'd2, 32'h0,         32'h0,         2'd0, 1'b1, 1'b1}, // R5 fetch RW
    '{3'd2, 32'h0000_2000, 32'hFFFF_FFFC, 2'd2, 32'h0000_1F00, 32'h0000_2000, 2'd3, 1'b0, 1'b0}, // R1 neg, R5
    '{3'd2, 32'h0000_1F00, 32'h0000_0004, 2'd0, 32'h0,         32'h0,         2'd0, 1'b1, 1'b0}, // R3 read XR
    '{3'd2, 32'h0000_1F00, 32'h0000_0000, 2'd1, 32'h0,         32'h0,         2'd0, 1'b1, 1'b1}, // R4 write XR
    '{3'd3, 32'h0000_8000, 32'h0000_0000, 2'd0, 32'h0000_8000, 32'h0000_9000, 2'd0, 1'b0, 1'b1}, // R3 NONE
    '{3'd3, 32'h0000_8000, 32'h0000_0004, 2'd0, 32'h0,         32'h0,         2'd0, 1'b1, 1'b1}, // R3 NONE hit
    '{3'd3, 32'h0000_8000, 32'h0000_0008, 2'd3, 32'h0,         32'h0,         2'd0, 1'b1, 1'b1}, // R5 reserved
    '{3'd1, 32'h0000_1000, 32'h0000_0000, 2'd0, 32'h0000_1000, 32'h0000_1100, 2'd1, 1'b0, 1'b0}, // R7 one region
    '{3'd0, 32'hFFFF_FFF0, 32'h0000_0020, 2'd0, 32'h0000_0000, 32'h0000_0040, 2'd2, 1'b0, 1'b0}  // R1 wrap
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_access(input logic [2:0] rg, input logic [31:0] val, input logic [31:0] imm,
                            input logic [1:0] kind, input logic [31:0] lo, input logic [31:0] hi,
                            input logic [1:0] pm, input bit exp_hit, input bit exp_flt,
                            input int dly, input bit inv, input string tag);
    logic [15:0] h0, m0;
    logic [31:0] ea;
    h0 = hits;
    m0 = misses;
    ea = val + imm;
    @(negedge clk);
    req_idx = rg; req_base = val; req_offset = imm; req_kind = kind; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (exp_hit) begin
      exp_hits++;
      chk(chk_done === 1'b1, {tag, " R2 hit done"}, {31'd0, chk_done}, 32'd1);
      chk(chk_fault === exp_flt, {tag, " R3/R4/R5 fault on hit"}, {31'd0, chk_fault}, {31'd0, exp_flt});
      chk(lkp_valid === 1'b0, {tag, " R2 no lookup"}, {31'd0, lkp_valid}, 32'd0);
      chk(hits == h0 + 16'd1 && misses == m0, {tag, " R9 hit count"}, {16'd0, hits}, {16'd0, h0 + 16'd1});
    end else begin
      exp_miss++;
      chk(chk_done === 1'b0 && lkp_valid === 1'b1, {tag, " R6 lookup raised"}, {31'd0, lkp_valid}, 32'd1);
      chk(lkp_addr === ea, {tag, " R1 lookup addr"}, lkp_addr, ea);
      chk(misses == m0 + 16'd1 && hits == h0, {tag, " R9 miss count"}, {16'd0, misses}, {16'd0, m0 + 16'd1});
      for (int k = 0; k < dly; k++) begin
        req_idx = rg + 3'd1; req_base = 32'hDEAD_0000; req_kind = 2'd0; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(lkp_valid === 1'b1 && busy === 1'b1 && lkp_addr === ea, {tag, " R6 hold"}, lkp_addr, ea);
        chk(misses == m0 + 16'd1 && hits == h0 && chk_done === 1'b0, {tag, " R6 ignored req"},
            {16'd0, misses}, {16'd0, m0 + 16'd1});
      end
      rsp_lo = lo; rsp_hi = hi; rsp_perm = pm; rsp_valid = 1'b1;
      if (inv) begin
        wr_en = 1'b1; wr_idx = rg;
      end
      @(negedge clk);
      rsp_valid = 1'b0;
      wr_en = 1'b0;
      chk(chk_done === 1'b1 && busy === 1'b0, {tag, " R7 done after rsp"}, {31'd0, chk_done}, 32'd1);
      chk(chk_fault === exp_flt, {tag, " R7 fault from rsp"}, {31'd0, chk_fault}, {31'd0, exp_flt});
    end
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; wr_en = 1'b0; rsp_valid = 1'b0;
    req_idx = '0; wr_idx = '0; req_base = '0; req_offset = '0; req_kind = '0;
    rsp_lo = '0; rsp_hi = '0; rsp_perm = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(chk_done === 1'b0 && chk_fault === 1'b0, "R10 reset outputs", {30'd0, chk_done, chk_fault}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy === 1'b0 && lkp_valid === 1'b0, "R10 idle after reset", {30'd0, busy, lkp_valid}, 32'd0);
    chk(hits == 16'd0 && misses == 16'd0, "R10 counters zero", {hits, misses}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      run_access(TBL[i].rg, TBL[i].val, TBL[i].imm, TBL[i].kind, TBL[i].lo, TBL[i].hi,
                 TBL[i].pm, TBL[i].hit, TBL[i].flt, 0, 1'b0, $sformatf("vec%0d", i));
    end

    // R8: write to another register leaves r2's sidecar intact
    @(negedge clk); wr_en = 1'b1; wr_idx = 3'd5;
    @(negedge clk); wr_en = 1'b0;
    run_access(3'd2, 32'h0000_1F00, 32'h8, 2'd0, 32'h0, 32'h0, 2'd0, 1'b1, 1'b0, 0, 1'b0, "R8 other kept");
    // R8: write to r1 drops its sidecar
    @(negedge clk); wr_en = 1'b1; wr_idx = 3'd1;
    @(negedge clk); wr_en = 1'b0;
    run_access(3'd1, 32'h0000_1000, 32'h4, 2'd0, 32'h0000_1000, 32'h0000_1100, 2'd1, 1'b0, 1'b0, 0, 1'b0, "R8 dropped");
    run_access(3'd1, 32'h0000_1000, 32'h8, 2'd0, 32'h0, 32'h0, 2'd0, 1'b1, 1'b0, 0, 1'b0, "R7 refill hit");

    // R6: stretched lookup with requests issued while busy
    run_access(3'd6, 32'h0000_3000, 32'h8, 2'd1, 32'h0000_3000, 32'h0000_3010, 2'd2, 1'b0, 1'b0, 3, 1'b0, "R6 slow rsp");
    run_access(3'd6, 32'h0000_300C, 32'h0, 2'd1, 32'h0, 32'h0, 2'd0, 1'b1, 1'b0, 0, 1'b0, "R6 after slow");

    // R11: invalidate in the refill cycle leaves the sidecar empty
    run_access(3'd4, 32'h0000_4000, 32'h0, 2'd0, 32'h0000_4000, 32'h0000_5000, 2'd2, 1'b0, 1'b0, 0, 1'b1, "R11 collide");
    run_access(3'd4, 32'h0000_4000, 32'h0, 2'd0, 32'h0000_4000, 32'h0000_5000, 2'd2, 1'b0, 1'b0, 0, 1'b0, "R11 miss again");

    @(negedge clk);
    chk(hits == 16'(exp_hits), "R9 total hits", {16'd0, hits}, exp_hits);
    chk(misses == 16'(exp_miss), "R9 total misses", {16'd0, misses}, exp_miss);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog R6 actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

endmodule